// File: doc/BRIEF.md
# High-Speed Sampling Delay Trim Sequencer

This block drives a register-access port, one access at a time, to apply or remove a manual trim on the sampling delay calibration of a storage-card host. To apply the trim, it first unlocks the port. It then reads back the calibration code that the automatic loop has chosen and lowers that code by a configurable trim, saturating at zero. It writes the result back with a manual-mode flag set and loads a small offset register. To remove the trim, it unlocks the port, clears the manual calibration word and zeroes the offset.

The apply sequence runs only when the feature is enabled and an arm flag is set. The arm flag is set when the link enters the high-speed double-data-rate mode and cleared when tuning selection starts. A completed apply sequence also clears the flag, so the trim is applied at most once for each arm. A one-cycle done pulse marks the end of either sequence. Each access uses a plain request/acknowledge handshake.

Top module: `cal_trim_seq`

## Requirements
- R1: The apply sequence performs these accesses in order: a write of the key 0xA5000000 to address 0x00, a read of address 0x26, and a write to address 0x22. The offset register is then updated.
- R2: The calibration code is bits [4:0] of the read data. All higher read-data bits are ignored.
- R3: The adjusted code equals code minus `trim` when code is greater than `trim`. Otherwise it is 0, and this includes the case code equal to `trim`.
- R4: The word written to address 0x22 in the apply sequence has bit 7 set, the adjusted code in bits [4:0], and every other bit clear.
- R5: `offset_q` resets to 0. It takes `off_val` when an apply sequence completes and becomes 0 when a remove sequence completes.
- R6: The remove sequence writes the key 0xA5000000 to address 0x00 and then writes 0 to address 0x22.
- R7: An apply request while `feat_en` is low, or while the arm flag is clear, makes no access, raises no done pulse and leaves the arm flag unchanged.
- R8: `arm_set` sets the arm flag and `arm_clr` clears it; `arm_clr` wins if both are high. Completing an apply sequence clears the flag.
- R9: `pa_req` stays high, and address, direction and write data stay stable, until `pa_ack`. The next access starts only after that acknowledge.
- R10: `done` is high for exactly one cycle. It rises in the cycle after the acknowledge of the last access, together with the `offset_q` update, and `pa_req` is low in that cycle.
- R11: Requests that arrive while a sequence is running are ignored. If apply and remove requests arrive in the same idle cycle, the remove sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Manual trim feature enabled |
| arm_set | input | 1 | Entry to high-speed DDR mode; sets arm flag |
| arm_clr | input | 1 | Tuning selection started; clears arm flag |
| en_req | input | 1 | Apply request pulse |
| dis_req | input | 1 | Remove request pulse |
| trim | input | 5 | Value subtracted from the calibration code |
| off_val | input | 2 | Offset loaded on apply |
| pa_req | output | 1 | Port access request |
| pa_wr | output | 1 | 1 = write, 0 = read |
| pa_addr | output | 6 | Port address |
| pa_wdata | output | 32 | Port write data |
| pa_ack | input | 1 | Port access acknowledge |
| pa_rdata | input | 32 | Port read data, valid with acknowledge |
| offset_q | output | 2 | Offset register |
| done | output | 1 | One-cycle sequence completion pulse |

## Verification
A wrong sequencer state shows up on the port at the next access. It appears as a wrong address, a wrong direction or a missing unlock, and it is visible on the first request after the state goes astray. A wrong arm flag shows up only at the next apply request, where a sequence runs that should not, or fails to run. A bad subtraction shows up in the data of the single write to address 0x22. The bench therefore logs every access together with its data, and it compares the log and the done pulse after each scenario. It uses several acknowledge latencies and codes below, equal to and above the trim.

// File: rtl/cal_trim_seq.sv
module cal_trim_seq #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int CODE_W     = 5,
  parameter int OFF_W      = 2,
  parameter int MANUAL_BIT = 7,
  parameter logic [31:0] UNLOCK_KEY = 32'hA500_0000,
  parameter logic [5:0]  A_UNLOCK   = 6'h00,
  parameter logic [5:0]  A_CODE     = 6'h26,
  parameter logic [5:0]  A_CAL      = 6'h22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic [CODE_W-1:0] trim,
  input  logic [OFF_W-1:0]  off_val,
  output logic              pa_req,
  output logic              pa_wr,
  output logic [ADDR_W-1:0] pa_addr,
  output logic [DATA_W-1:0] pa_wdata,
  input  logic              pa_ack,
  input  logic [DATA_W-1:0] pa_rdata,
  output logic [OFF_W-1:0]  offset_q,
  output logic              done
);

  typedef enum logic [2:0] {
    S_IDLE, S_EN_KEY, S_EN_RD, S_EN_WR, S_DIS_KEY, S_DIS_WR
  } st_t;

  st_t               st;
  logic              armed;
  logic [CODE_W-1:0] adj_q;
  logic [CODE_W-1:0] code;
  logic              unused_rd;

  assign code      = pa_rdata[CODE_W-1:0];
  assign unused_rd = ^pa_rdata[DATA_W-1:CODE_W];

  assign pa_req = (st != S_IDLE);
  assign pa_wr  = (st != S_EN_RD);

  always_comb begin
    pa_addr  = ADDR_W'(A_UNLOCK);
    pa_wdata = '0;
    case (st)
      S_EN_KEY, S_DIS_KEY: pa_wdata = DATA_W'(UNLOCK_KEY);
      S_EN_RD:             pa_addr  = ADDR_W'(A_CODE);
      S_EN_WR: begin
        pa_addr  = ADDR_W'(A_CAL);
        pa_wdata = (DATA_W'(1) << MANUAL_BIT) | DATA_W'(adj_q);
      end
      S_DIS_WR:            pa_addr  = ADDR_W'(A_CAL);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      armed    <= 1'b0;
      adj_q    <= '0;
      offset_q <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (arm_clr)      armed <= 1'b0;
      else if (arm_set) armed <= 1'b1;
      case (st)
        S_IDLE:
          if (dis_req)                        st <= S_DIS_KEY;
          else if (en_req && feat_en && armed) st <= S_EN_KEY;
        S_EN_KEY:  if (pa_ack) st <= S_EN_RD;
        S_EN_RD:
          if (pa_ack) begin
            adj_q <= (code > trim) ? code - trim : '0;
            st    <= S_EN_WR;
          end
        S_EN_WR:
          if (pa_ack) begin
            offset_q <= off_val;
            done     <= 1'b1;
            armed    <= 1'b0;
            st       <= S_IDLE;
          end
        S_DIS_KEY: if (pa_ack) st <= S_DIS_WR;
        S_DIS_WR:
          if (pa_ack) begin
            offset_q <= '0;
            done     <= 1'b1;
            st       <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module cal_trim_seq_chk #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int CODE_W     = 5,
  parameter int OFF_W      = 2,
  parameter int MANUAL_BIT = 7,
  parameter logic [5:0] A_CAL = 6'h22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_clr,
  input logic              armed,
  input logic              pa_req,
  input logic              pa_wr,
  input logic [ADDR_W-1:0] pa_addr,
  input logic [DATA_W-1:0] pa_wdata,
  input logic              pa_ack,
  input logic [OFF_W-1:0]  offset_q,
  input logic              done
);
  localparam logic [DATA_W-1:0] ALLOWED =
    (DATA_W'(1) << MANUAL_BIT) | DATA_W'((1 << CODE_W) - 1);

  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    pa_req && !pa_ack |=> pa_req && $stable(pa_addr) && $stable(pa_wr) && $stable(pa_wdata));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pa_req);

  a_r5_offset_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_q) |-> done);

  a_r4_cal_word_fields: assert property (@(posedge clk) disable iff (!rst_n)
    pa_req && pa_wr && pa_addr == ADDR_W'(A_CAL) |-> (pa_wdata & ~ALLOWED) == '0);

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr |=> !armed);
endmodule

bind cal_trim_seq cal_trim_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .OFF_W(OFF_W),
  .MANUAL_BIT(MANUAL_BIT), .A_CAL(A_CAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_clr(arm_clr), .armed(armed),
  .pa_req(pa_req), .pa_wr(pa_wr), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
  .pa_ack(pa_ack), .offset_q(offset_q), .done(done)
);

// File: tb/cal_trim_seq_test.sv
module cal_trim_seq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        feat_en = 0, arm_set = 0, arm_clr = 0, en_req = 0, dis_req = 0;
  logic [4:0]  trim = 0;
  logic [1:0]  off_val = 0;
  logic        pa_req, pa_wr, pa_ack = 0, done;
  logic [5:0]  pa_addr;
  logic [31:0] pa_wdata, pa_rdata;
  logic [1:0]  offset_q;

  int checks = 0, fails = 0;
  int lat = 0, cnt = 0;
  logic [31:0] rd_val = 0;
  int log_n = 0;
  logic [5:0]  lg_addr [16];
  logic        lg_wr   [16];
  logic [31:0] lg_data [16];

  assign pa_rdata = rd_val;

  always #10 clk = ~clk;

  cal_trim_seq uut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .arm_set(arm_set), .arm_clr(arm_clr),
    .en_req(en_req), .dis_req(dis_req), .trim(trim), .off_val(off_val),
    .pa_req(pa_req), .pa_wr(pa_wr), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
    .pa_ack(pa_ack), .pa_rdata(pa_rdata), .offset_q(offset_q), .done(done)
  );

  always @(posedge clk) begin
    if (pa_ack) begin
      pa_ack <= 1'b0;
      cnt    <= 0;
    end else if (pa_req) begin
      if (cnt >= lat) begin
        pa_ack <= 1'b1;
        if (log_n < 16) begin
          lg_addr[log_n] = pa_addr;
          lg_wr[log_n]   = pa_wr;
          lg_data[log_n] = pa_wdata;
        end
        log_n = log_n + 1;
      end else cnt <= cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_en(); en_req = 1; @(negedge clk); en_req = 0; endtask
  task automatic pulse_dis(); dis_req = 1; @(negedge clk); dis_req = 0; endtask
  task automatic pulse_arm(); arm_set = 1; @(negedge clk); arm_set = 0; endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        check(offset_q === off_val || offset_q === 2'b00, "R10 offset settles with done", offset_q, off_val);
        @(negedge clk);
        check(done === 1'b0, "R10 done lasts one cycle", done, 0);
        return;
      end
    end
  endtask

  task automatic test_reset();
    check(pa_req === 0 && done === 0, "R10 reset idle", {pa_req, done}, 0);
    check(offset_q === 0, "R5 reset offset", offset_q, 0);
  endtask

  task automatic test_apply(input logic [31:0] rd, input logic [4:0] tr, input logic [1:0] ov, input int l);
    bit seen;
    logic [4:0] c;
    logic [4:0] exp_adj;
    rd_val = rd; trim = tr; off_val = ov; lat = l; log_n = 0;
    c = rd[4:0];
    exp_adj = (c > tr) ? c - tr : 5'd0;
    pulse_en();
    wait_done(seen);
    check(seen, "R1 apply done", seen, 1);
    check(log_n == 3, "R1 access count", log_n, 3);
    check(lg_addr[0] == 6'h00 && lg_wr[0] && lg_data[0] == 32'hA500_0000, "R1 unlock first", lg_data[0], 32'hA500_0000);
    check(lg_addr[1] == 6'h26 && !lg_wr[1], "R1 read of code", {lg_wr[1], lg_addr[1]}, 6'h26);
    check(lg_addr[2] == 6'h22 && lg_wr[2], "R1 write of cal word", lg_addr[2], 6'h22);
    check(lg_data[2] == (32'h80 | {27'd0, exp_adj}), "R2 R3 R4 cal word", lg_data[2], 32'h80 | {27'd0, exp_adj});
    check(offset_q == ov, "R5 offset after apply", offset_q, ov);
  endtask

  task automatic test_ignored(input string tag);
    bit seen;
    log_n = 0;
    pulse_en();
    wait_done(seen);
    check(!seen && log_n == 0, tag, log_n, 0);
  endtask

  task automatic test_remove(input int l);
    bit seen;
    lat = l; log_n = 0;
    pulse_dis();
    wait_done(seen);
    check(seen && log_n == 2, "R6 remove accesses", log_n, 2);
    check(lg_addr[0] == 6'h00 && lg_wr[0] && lg_data[0] == 32'hA500_0000, "R6 unlock", lg_data[0], 32'hA500_0000);
    check(lg_addr[1] == 6'h22 && lg_wr[1] && lg_data[1] == 0, "R6 clear cal word", lg_data[1], 0);
    check(offset_q == 0, "R5 offset zeroed", offset_q, 0);
  endtask

  task automatic test_busy();
    bit seen;
    lat = 5; log_n = 0;
    pulse_dis();
    repeat (3) @(negedge clk);
    pulse_en();
    pulse_dis();
    wait_done(seen);
    check(seen && log_n == 2, "R11 request during sequence ignored", log_n, 2);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(!seen && log_n == 2, "R11 no later sequence", log_n, 2);
  endtask

  task automatic test_both();
    bit seen;
    lat = 0; log_n = 0;
    en_req = 1; dis_req = 1; @(negedge clk); en_req = 0; dis_req = 0;
    wait_done(seen);
    check(seen && log_n == 2 && lg_data[1] == 0, "R11 remove wins over apply", log_n, 2);
  endtask

  initial begin
    repeat (4000) @(negedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    feat_en = 1;
    test_ignored("R7 apply without arm ignored");
    pulse_arm();
    test_apply(32'hFFFF_FFF7, 5'd9, 2'd3, 0);
    test_ignored("R8 arm cleared by completed apply");
    pulse_arm();
    test_apply(32'h0000_0005, 5'd9, 2'd1, 2);
    pulse_arm();
    test_apply(32'h1234_5669, 5'd9, 2'd2, 1);
    pulse_arm();
    feat_en = 0;
    test_ignored("R7 apply with feature off ignored");
    feat_en = 1;
    test_apply(32'h0000_001F, 5'd0, 2'd3, 3);
    pulse_arm();
    arm_clr = 1; @(negedge clk); arm_clr = 0;
    test_ignored("R8 arm_clr clears flag");
    arm_set = 1; arm_clr = 1; @(negedge clk); arm_set = 0; arm_clr = 0;
    test_ignored("R8 arm_clr wins over arm_set");
    test_remove(0);
    pulse_arm();
    test_apply(32'h0000_0010, 5'd4, 2'd1, 0);
    test_remove(4);
    pulse_arm();
    test_busy();
    test_both();
    test_apply(32'h0000_000C, 5'd4, 2'd2, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule